// File: doc/BRIEF.md
# Result Router Between Unit Queues

This block carries operand values from the output queues of functional units to the input queues of other functional units. The instructions that produce results hold no destination information. A separate stream of route items supplies every movement instead. Each item picks one producer queue and one consumer queue. A single flag bit on the item says whether the value is used for the last time. Routing is therefore decided apart from the producing instruction. One result can fan out to several consumers, one item at a time, without duplicate instructions.

The route items are served strictly in arrival order, at most one per cycle. An item waits until its producer has a value and its consumer accepts it. Every port carries a valid/ready handshake, and consumers take operands from their queue heads in the order they arrive. An item whose producer or consumer code names no port is dropped and raises an error pulse. A counter gives the number of completed moves.

Top module: `rr_router`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `item_ready` is 1, all `dst_valid` and `src_ready` bits are 0, `xfer_count` is 0 and `route_err` is 0.
- R2: A route item is 7 bits: bits [2:0] give the producer port, bits [5:3] give the consumer port and bit 6 is the last-use flag. When the item is served, only the chosen consumer sees `dst_valid`, and its `dst_data` equals the current head value of the chosen producer.
- R3: When the last-use flag is 1, the producer head is popped (`src_ready` high) in the cycle of the move. When the flag is 0, the head stays, so the next item naming that producer gets the same value.
- R4: Items are served in the order they are accepted. Consumers receive values in that same order. With every producer valid and every consumer ready, N legal back-to-back items complete in N+1 cycles from the first acceptance.
- R5: An item waits while its producer is empty or its consumer is not ready. No producer is popped while it waits. A consumer that sees `dst_valid` without `ready` keeps `dst_valid` high with unchanged data in the next cycle.
- R6: An item with a producer or consumer code of 5 to 7 is discarded. It moves no data, `route_err` pulses for one cycle in the cycle after it is dropped, and the next item proceeds.
- R7: `xfer_count` grows by exactly one in the cycle after each completed move (consumer valid and ready) and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| item_valid | input | 1 | Route item offered |
| item_ready | output | 1 | Route item taken this cycle |
| item_data | input | 7 | Route item: last flag, consumer code, producer code |
| src_valid | input | NUM_PORTS | Producer queue heads hold data |
| src_ready | output | NUM_PORTS | Pop the producer queue head |
| src_data | input | NUM_PORTS*DATA_W | Producer head values, port p at bits [p*DATA_W +: DATA_W] |
| dst_valid | output | NUM_PORTS | Value offered to consumer queue |
| dst_ready | input | NUM_PORTS | Consumer queue accepts |
| dst_data | output | NUM_PORTS*DATA_W | Value for each consumer, same layout as src_data |
| route_err | output | 1 | One-cycle pulse for a dropped item |
| xfer_count | output | CNT_W | Completed moves |

## Verification
The bench builds the block with its defaults: five ports, 16-bit data and a 16-bit counter. With five ports and 3-bit codes, codes 5, 6 and 7 all exist on the item bus, so dropped items can be driven next to legal ones. Random consumer readiness and producer refills make both kinds of stall occur. The tagged data values let a copied value be told apart from a popped one.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
  localparam int SEL_W  = 3;
  localparam int ITEM_W = 2 * SEL_W + 1;

  // bit 6 last-use flag, bits 5:3 consumer, bits 2:0 producer
  typedef struct packed {
    logic             last;
    logic [SEL_W-1:0] dst;
    logic [SEL_W-1:0] src;
  } route_item_t;
endpackage

// File: rtl/rr_item_stage.sv
`timescale 1ns/1ps
module rr_item_stage
  import rr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  route_item_t in_item,
  input  logic        done,
  output logic        in_ready,
  output logic        held_v,
  output route_item_t held
);
  // a new item enters when the slot is empty or its item finishes now
  always_comb in_ready = !held_v || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v <= 1'b0;
      held   <= '0;
    end else if (in_ready) begin
      held_v <= in_valid;
      held   <= in_item;
    end
  end
endmodule

// File: rtl/rr_xbar.sv
`timescale 1ns/1ps
module rr_xbar
  import rr_pkg::*;
#(
  parameter int N = 5,
  parameter int W = 16
) (
  input  logic          held_v,
  input  route_item_t   held,
  input  logic [N-1:0]  src_valid,
  input  logic [N*W-1:0] src_data,
  input  logic [N-1:0]  dst_ready,
  output logic [N-1:0]  dst_valid,
  output logic [N*W-1:0] dst_data,
  output logic [N-1:0]  src_ready,
  output logic          xfer,
  output logic          illegal
);
  logic [N-1:0] src_hit, dst_hit;
  logic         legal, sel_v, sel_rdy, go;
  logic [W-1:0] sel_d;

  generate
    for (genvar i = 0; i < N; i++) begin : g_dec
      assign src_hit[i] = (held.src == SEL_W'(i));
      assign dst_hit[i] = (held.dst == SEL_W'(i));
    end
  endgenerate

  // a code at or above N hits no port, which marks the item illegal
  always_comb begin
    legal   = (|src_hit) && (|dst_hit);
    sel_v   = |(src_hit & src_valid);
    sel_rdy = |(dst_hit & dst_ready);
    sel_d   = '0;
    for (int i = 0; i < N; i++)
      if (src_hit[i]) sel_d = src_data[i*W +: W];
    go      = held_v && legal && sel_v;
    xfer    = go && sel_rdy;
    illegal = held_v && !legal;
  end

  generate
    for (genvar p = 0; p < N; p++) begin : g_port
      assign dst_valid[p]        = go && dst_hit[p];
      assign dst_data[p*W +: W]  = sel_d;
      assign src_ready[p]        = xfer && held.last && src_hit[p];
    end
  endgenerate
endmodule

// File: rtl/rr_stats.sv
`timescale 1ns/1ps
module rr_stats #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  logic          illegal,
  output logic [CW-1:0] count,
  output logic          err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      err   <= 1'b0;
    end else begin
      if (xfer) count <= count + 1'b1;
      err <= illegal;
    end
  end
endmodule

// File: rtl/rr_router.sv
`timescale 1ns/1ps
module rr_router
  import rr_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        item_valid,
  output logic                        item_ready,
  input  logic [ITEM_W-1:0]           item_data,
  input  logic [NUM_PORTS-1:0]        src_valid,
  output logic [NUM_PORTS-1:0]        src_ready,
  input  logic [NUM_PORTS*DATA_W-1:0] src_data,
  output logic [NUM_PORTS-1:0]        dst_valid,
  input  logic [NUM_PORTS-1:0]        dst_ready,
  output logic [NUM_PORTS*DATA_W-1:0] dst_data,
  output logic                        route_err,
  output logic [CNT_W-1:0]            xfer_count
);
  route_item_t held;
  logic        held_v, xfer, illegal, done;

  assign done = xfer || illegal;

  rr_item_stage u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (item_valid),
    .in_item  (route_item_t'(item_data)),
    .done     (done),
    .in_ready (item_ready),
    .held_v   (held_v),
    .held     (held)
  );

  rr_xbar #(.N(NUM_PORTS), .W(DATA_W)) u_xbar (
    .held_v    (held_v),
    .held      (held),
    .src_valid (src_valid),
    .src_data  (src_data),
    .dst_ready (dst_ready),
    .dst_valid (dst_valid),
    .dst_data  (dst_data),
    .src_ready (src_ready),
    .xfer      (xfer),
    .illegal   (illegal)
  );

  rr_stats #(.CW(CNT_W)) u_stats (
    .clk     (clk),
    .rst     (rst),
    .xfer    (xfer),
    .illegal (illegal),
    .count   (xfer_count),
    .err     (route_err)
  );
endmodule

// File: rtl/rr_router_chk.sv
`timescale 1ns/1ps
module rr_router_chk #(
  parameter int N  = 5,
  parameter int W  = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          item_ready,
  input logic [N-1:0]  src_valid,
  input logic [N-1:0]  src_ready,
  input logic [N-1:0]  dst_valid,
  input logic [N-1:0]  dst_ready,
  input logic [N*W-1:0] dst_data,
  input logic          route_err,
  input logic [CW-1:0] xfer_count
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_quiet_reset_R1: assert property (@(posedge clk)
    armed && $past(rst) |-> item_ready && dst_valid == '0 && src_ready == '0
                            && xfer_count == '0 && !route_err);

  assert_one_dest_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dst_valid));

  assert_pop_with_move_R3: assert property (@(posedge clk) disable iff (rst)
    (|src_ready) |-> (|(dst_valid & dst_ready)) && $onehot0(src_ready)
                     && ((src_ready & ~src_valid) == '0));

  generate
    for (genvar d = 0; d < N; d++) begin : g_hold
      assert_hold_stall_R5: assert property (@(posedge clk) disable iff (rst)
        dst_valid[d] && !dst_ready[d] |=> dst_valid[d] && $stable(dst_data[d*W +: W]));
    end
  endgenerate

  assert_err_no_move_R6: assert property (@(posedge clk) disable iff (rst)
    route_err |-> $past(dst_valid) == '0);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (|(dst_valid & dst_ready)) |=> xfer_count == $past(xfer_count) + 1'b1);

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(|(dst_valid & dst_ready)) |=> $stable(xfer_count));
endmodule

bind rr_router rr_router_chk #(.N(NUM_PORTS), .W(DATA_W), .CW(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .item_ready (item_ready),
  .src_valid  (src_valid),
  .src_ready  (src_ready),
  .dst_valid  (dst_valid),
  .dst_ready  (dst_ready),
  .dst_data   (dst_data),
  .route_err  (route_err),
  .xfer_count (xfer_count)
);

// File: tb/rr_router_test.sv
`timescale 1ns/1ps
module rr_router_test;
  localparam int NP = 5;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int QD = 128;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            item_valid = 1'b0;
  logic            item_ready;
  logic [6:0]      item_data = '0;
  logic [NP-1:0]   src_valid = '0;
  logic [NP-1:0]   src_ready;
  logic [NP*DW-1:0] src_data = '0;
  logic [NP-1:0]   dst_valid;
  logic [NP-1:0]   dst_ready = '0;
  logic [NP*DW-1:0] dst_data;
  logic            route_err;
  logic [CW-1:0]   xfer_count;

  always #4 clk = ~clk;

  rr_router #(.NUM_PORTS(NP), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .item_valid(item_valid), .item_ready(item_ready),
    .item_data(item_data), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .dst_valid(dst_valid), .dst_ready(dst_ready),
    .dst_data(dst_data), .route_err(route_err), .xfer_count(xfer_count)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] sq [NP][QD];
  int sq_head [NP], sq_tail [NP], m_head [NP];
  int seq = 0;
  logic [6:0] it_data [1024];
  int it_n = 0, it_idx = 0, legal_n = 0, illegal_n = 0;
  int pf_src [1024], pf_dst [1024];
  bit pf_last [1024];
  int pf_wr = 0, pf_rd = 0;
  int rx_n = 0, err_n = 0, steps = 0;
  bit hold_prev [NP];
  logic [DW-1:0] hold_val [NP];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] mk(input bit last, input int dst, input int src);
    return {last, 3'(dst), 3'(src)};
  endfunction

  function automatic bit is_legal(input logic [6:0] it);
    return (it[2:0] < 3'd5) && (it[5:3] < 3'd5);
  endfunction

  task automatic add_item(input logic [6:0] it);
    it_data[it_n] = it;
    it_n++;
    if (is_legal(it)) legal_n++; else illegal_n++;
  endtask

  task automatic push_src(input int s);
    if (sq_tail[s] < QD) begin
      sq[s][sq_tail[s]] = {4'(s), 12'(seq)};
      seq++;
      sq_tail[s]++;
    end
  endtask

  task automatic step(input logic [NP-1:0] rmask, input int rdy_pct, input int refill_pct);
    @(negedge clk);
    for (int s = 0; s < NP; s++)
      if (refill_pct > 0 && $urandom_range(99) < refill_pct) push_src(s);
    item_valid = (it_idx < it_n);
    item_data  = (it_idx < it_n) ? it_data[it_idx] : 7'd0;
    for (int d = 0; d < NP; d++)
      dst_ready[d] = rmask[d] && ($urandom_range(99) < rdy_pct);
    for (int s = 0; s < NP; s++) begin
      src_valid[s] = (sq_head[s] < sq_tail[s]);
      src_data[s*DW +: DW] = src_valid[s] ? sq[s][sq_head[s]] : '0;
    end
    #1;
    if (route_err) err_n++;
    // R5: a stalled offer stays up with the same value
    for (int d = 0; d < NP; d++)
      if (hold_prev[d])
        chk(dst_valid[d] && dst_data[d*DW +: DW] == hold_val[d], "R5 stalled offer",
            int'(dst_data[d*DW +: DW]), int'(hold_val[d]));
    if ($countones(dst_valid) > 1) chk(1'b0, "R2 one consumer", $countones(dst_valid), 1);
    for (int d = 0; d < NP; d++) begin
      if (dst_valid[d] && dst_ready[d]) begin
        if (pf_rd < pf_wr) begin
          int s;
          s = pf_src[pf_rd];
          chk(d == pf_dst[pf_rd], "R4 consumer order", d, pf_dst[pf_rd]);
          chk(dst_data[d*DW +: DW] == sq[s][m_head[s]], "R2 routed value",
              int'(dst_data[d*DW +: DW]), int'(sq[s][m_head[s]]));
          if (pf_last[pf_rd]) m_head[s]++;
          pf_rd++;
        end else begin
          chk(1'b0, "R4 unexpected move", d, -1);
        end
        rx_n++;
      end
    end
    for (int s = 0; s < NP; s++)
      if (src_ready[s] && src_valid[s]) sq_head[s]++;
    if (item_valid && item_ready) begin
      if (is_legal(item_data)) begin
        pf_src[pf_wr]  = int'(item_data[2:0]);
        pf_dst[pf_wr]  = int'(item_data[5:3]);
        pf_last[pf_wr] = item_data[6];
        pf_wr++;
      end
      it_idx++;
    end
    for (int d = 0; d < NP; d++) begin
      hold_prev[d] = dst_valid[d] && !dst_ready[d];
      hold_val[d]  = dst_data[d*DW +: DW];
    end
    steps++;
  endtask

  task automatic drain(input int rdy_pct, input int refill_pct);
    while (it_idx < it_n || pf_rd < pf_wr) step('1, rdy_pct, refill_pct);
    repeat (3) step('1, 100, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", steps, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, e0, c0, s0, h0;
    void'($urandom(32'd2024));
    for (int s = 0; s < NP; s++) begin
      sq_head[s] = 0; sq_tail[s] = 0; m_head[s] = 0; hold_prev[s] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(item_ready == 1'b1, "R1 item_ready", int'(item_ready), 1);
    chk(dst_valid == '0, "R1 dst_valid", int'(dst_valid), 0);
    chk(src_ready == '0, "R1 src_ready", int'(src_ready), 0);
    chk(xfer_count == '0, "R1 count", int'(xfer_count), 0);
    chk(route_err == 1'b0, "R1 err", int'(route_err), 0);

    // R3: one value copied twice, then used for the last time
    push_src(0);
    r0 = rx_n;
    add_item(mk(0, 1, 0)); add_item(mk(0, 2, 0)); add_item(mk(1, 3, 0));
    drain(100, 0);
    chk(rx_n - r0 == 3, "R3 fanout moves", rx_n - r0, 3);
    chk(sq_head[0] == 1, "R3 single pop", sq_head[0], 1);

    // R4: back-to-back throughput with all sides ready
    for (int k = 0; k < 2; k++) begin push_src(1); push_src(2); push_src(4); end
    r0 = rx_n;
    add_item(mk(1, 0, 1)); add_item(mk(0, 3, 2)); add_item(mk(1, 1, 4));
    add_item(mk(1, 0, 2)); add_item(mk(0, 4, 1)); add_item(mk(1, 2, 4));
    s0 = steps;
    while (rx_n - r0 < 6 && steps - s0 < 50) step('1, 100, 0);
    chk(steps - s0 == 7, "R4 cycles for 6 items", steps - s0, 7);
    drain(100, 0);

    // R6: illegal codes are dropped and flagged
    r0 = rx_n; e0 = err_n; c0 = int'(xfer_count);
    add_item(mk(1, 0, 5)); add_item(mk(0, 7, 0)); add_item(mk(1, 6, 6));
    drain(100, 0);
    chk(err_n - e0 == 3, "R6 error pulses", err_n - e0, 3);
    chk(rx_n == r0, "R6 no move", rx_n, r0);
    chk(int'(xfer_count) == c0, "R6 count unchanged", int'(xfer_count), c0);

    // R5: consumer not ready
    push_src(2);
    h0 = sq_head[2];
    add_item(mk(1, 4, 2));
    repeat (5) step(5'b01111, 100, 0);
    chk(sq_head[2] == h0, "R5 no pop while blocked", sq_head[2], h0);
    chk(dst_valid[4] == 1'b1, "R5 offer held", int'(dst_valid[4]), 1);
    drain(100, 0);
    chk(sq_head[2] == h0 + 1, "R3 pop after release", sq_head[2], h0 + 1);

    // R5: producer empty
    r0 = rx_n;
    add_item(mk(1, 0, 3));
    repeat (4) begin
      step('1, 100, 0);
      chk(dst_valid == '0, "R5 waits for producer", int'(dst_valid), 0);
    end
    push_src(3);
    drain(100, 0);
    chk(rx_n - r0 == 1, "R5 move after fill", rx_n - r0, 1);

    // random mix of legal and illegal items
    for (int s = 0; s < NP; s++) repeat (50) push_src(s);
    for (int k = 0; k < 200; k++)
      add_item(mk($urandom_range(1), $urandom_range(5), $urandom_range(5)));
    drain(60, 5);

    chk(int'(xfer_count) == rx_n, "R7 count matches moves", int'(xfer_count), rx_n);
    chk(rx_n == legal_n, "R4 every legal item moved", rx_n, legal_n);
    chk(err_n == illegal_n, "R6 every illegal flagged", err_n, illegal_n);
    for (int s = 0; s < NP; s++)
      chk(sq_head[s] == m_head[s], "R3 pops per producer", sq_head[s], m_head[s]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule